// File: doc/BRIEF.md
# Register Rename Map with Ready Scoreboard

This block holds the mapping from architectural to physical registers for an out-of-order core, and one ready bit for each physical register. Integer, floating-point and miscellaneous registers share one architectural index space. Integer logical registers come first and floating-point logical registers follow. Miscellaneous registers sit above all logical registers. Physical indices use the same order: integer physical registers, then floating-point physical registers, then the miscellaneous registers above the total physical count.

Each cycle the block can take one destination rename, one source lookup, one ready-bit query, one writeback ready-mark and one mapping override used by recovery. A rename of an integer or floating-point register takes a register from the free list of its class through a pop/valid handshake. The rename response is combinational in the same cycle, and the map and ready bits change at the next clock edge. Miscellaneous registers are never remapped: their physical index is a fixed offset from their architectural index. The block also reports how many renames can still be supplied, which is the smaller of the two free-list counts.

Top module: `regmap_sb`

## Requirements
- R1: After reset, integer logical register i maps to physical i. Floating-point logical register LOG_INT+k maps to physical PHYS_INT+k. A lookup returns these values.
- R2: After reset, the ready bit is set for physical 0..LOG_INT-1, for PHYS_INT..PHYS_INT+LOG_FP-1, and for every miscellaneous index at PHYS_INT+PHYS_FP or above. All other ready bits are clear.
- R3: An accepted rename of a non-zero integer register (architectural index below LOG_INT) pops the integer free list once and returns that list's head as the new index. An accepted rename of a non-zero floating-point register (LOG_INT up to LOG_INT+LOG_FP-1) does the same with the floating-point free list. In both cases the previous index is the current mapping, and the map holds the new index from the next cycle.
- R4: From the cycle after a rename with a non-zero register, the ready bit of the returned new index reads clear. This holds even when a ready-mark of the same index occurs in the rename cycle.
- R5: A rename of the integer zero register (index ZERO_INT) or of the floating-point zero register (index ZERO_FP) is always accepted. It returns the architectural index as the new index and the current mapping as the previous index. It pops no free list, leaves the map unchanged and leaves all ready bits unchanged.
- R6: A rename of a miscellaneous register a is always accepted. It returns a-(LOG_INT+LOG_FP)+(PHYS_INT+PHYS_FP) as both the new and the previous index, pops no free list, and clears that index's ready bit.
- R7: A lookup returns the current mapping for an integer or floating-point register and the fixed offset index for a miscellaneous register. A rename of the same register in the same cycle does not change what the lookup returns.
- R8: A ready-mark sets the ready bit of any physical index in any range. A query of the same index in the same cycle already reads it as set.
- R9: An override writes a new mapping for an integer or floating-point register from the next cycle on, and takes priority over a same-cycle rename of that register. An override that targets a miscellaneous index is ignored.
- R10: A rename of a non-zero register whose class free list is not valid is stalled. ren_ready is low, nothing is popped, and the map is unchanged. A stall of one class does not block renames of the other class.
- R11: avail_count equals the minimum of int_fl_count and fp_fl_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | AW | Architectural destination to rename |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_new | output | PW | New physical index |
| ren_prev | output | PW | Previous physical index |
| int_fl_pop | output | 1 | Take the head of the integer free list |
| int_fl_valid | input | 1 | Integer free list head is valid |
| int_fl_phys | input | PW | Integer free list head |
| int_fl_count | input | CW | Integer free registers |
| fp_fl_pop | output | 1 | Take the head of the floating-point free list |
| fp_fl_valid | input | 1 | Floating-point free list head is valid |
| fp_fl_phys | input | PW | Floating-point free list head |
| fp_fl_count | input | CW | Floating-point free registers |
| lk_arch | input | AW | Architectural source to look up |
| lk_phys | output | PW | Current physical index of lk_arch |
| rdy_set | input | 1 | Ready-mark strobe |
| rdy_set_phys | input | PW | Physical index to mark ready |
| rdy_query_phys | input | PW | Physical index to query |
| rdy_query_out | output | 1 | Ready bit of rdy_query_phys |
| ovr_valid | input | 1 | Mapping override strobe |
| ovr_arch | input | AW | Architectural register to override |
| ovr_phys | input | PW | Physical index to write |
| avail_count | output | CW | Renames that can still be supplied |

AW = clog2(LOG_INT+LOG_FP+NUM_MISC), PW = clog2(PHYS_INT+PHYS_FP+NUM_MISC), CW = clog2(max(PHYS_INT,PHYS_FP)+1).

## Verification
Two collisions matter most. The first is a writeback ready-mark that lands in the same cycle as a rename that clears the same physical index. The bench sets up this collision by marking the current integer free-list head while renaming an integer register. The same-cycle query must read the bit as set through the bypass, and the query in the following cycle must read it as clear. The second collision pairs a rename with a lookup or an override of the same architectural register in one cycle. Here the lookup must return the old mapping, and the override must decide the new one.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

    typedef enum logic [1:0] {
        RC_INT  = 2'd0,
        RC_FP   = 2'd1,
        RC_MISC = 2'd2
    } reg_class_e;

endpackage

// File: rtl/regmap_classify.sv
module regmap_classify
    import regmap_pkg::*;
#(
    parameter int LI  = 8,
    parameter int LF  = 8,
    parameter int NPF = 32,
    parameter int AW  = 5,
    parameter int PW  = 6
) (
    input  logic [AW-1:0] arch,
    output reg_class_e    cls,
    output logic [PW-1:0] fixed_phys
);
    localparam int NL = LI + LF;
    localparam logic [AW-1:0] LI_A = AW'(LI);
    localparam logic [AW-1:0] NL_A = AW'(NL);

    always_comb begin
        if (arch < LI_A) begin
            cls = RC_INT;
        end else if (arch < NL_A) begin
            cls = RC_FP;
        end else begin
            cls = RC_MISC;
        end
        fixed_phys = PW'(int'(arch) - NL + NPF);
    end

endmodule

// File: rtl/regmap_table.sv
module regmap_table #(
    parameter int LI = 8,
    parameter int LF = 8,
    parameter int PI = 16,
    parameter int AW = 5,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_phys,
    input  logic          ov_en,
    input  logic [AW-1:0] ov_arch,
    input  logic [PW-1:0] ov_phys,
    input  logic [AW-1:0] rd_a_arch,
    output logic [PW-1:0] rd_a_phys,
    input  logic [AW-1:0] rd_b_arch,
    output logic [PW-1:0] rd_b_phys
);
    localparam int NL = LI + LF;
    localparam int IW = (NL > 1) ? $clog2(NL) : 1;
    localparam logic [AW-1:0] NL_A = AW'(NL);

    typedef struct packed {
        logic [NL-1:0][PW-1:0] ent;
    } map_s;

    function automatic map_s init_map();
        map_s m;
        for (int i = 0; i < NL; i++) begin
            m.ent[i] = (i < LI) ? PW'(i) : PW'(PI + i - LI);
        end
        return m;
    endfunction

    localparam map_s MAP_INIT = init_map();

    map_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_arch < NL_A) begin
            st_d.ent[wr_arch[IW-1:0]] = wr_phys;
        end
        // recovery write is applied last so it wins over a rename
        if (ov_en && ov_arch < NL_A) begin
            st_d.ent[ov_arch[IW-1:0]] = ov_phys;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= MAP_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_a_phys = (rd_a_arch < NL_A) ? st_q.ent[rd_a_arch[IW-1:0]] : '0;
        rd_b_phys = (rd_b_arch < NL_A) ? st_q.ent[rd_b_arch[IW-1:0]] : '0;
    end

endmodule

// File: rtl/regmap_scoreboard.sv
module regmap_scoreboard #(
    parameter int LI = 8,
    parameter int PI = 16,
    parameter int LF = 8,
    parameter int PF = 16,
    parameter int NM = 4,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [PW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [PW-1:0] clr_idx,
    input  logic [PW-1:0] q_idx,
    output logic          q_rdy
);
    localparam int NPT = PI + PF + NM;
    localparam logic [PW-1:0] NPT_A = PW'(NPT);

    typedef struct packed {
        logic [NPT-1:0] rdy;
    } sb_s;

    function automatic logic [NPT-1:0] init_rdy();
        logic [NPT-1:0] v;
        for (int i = 0; i < NPT; i++) begin
            v[i] = (i < LI) || (i >= PI && i < PI + LF) || (i >= PI + PF);
        end
        return v;
    endfunction

    localparam logic [NPT-1:0] RDY_INIT = init_rdy();

    sb_s sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        if (set_en && set_idx < NPT_A) begin
            sb_d.rdy[set_idx] = 1'b1;
        end
        // a fresh allocation outranks a stale writeback mark
        if (clr_en && clr_idx < NPT_A) begin
            sb_d.rdy[clr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_q.rdy <= RDY_INIT;
        end else begin
            sb_q <= sb_d;
        end
    end

    always_comb begin
        q_rdy = ((q_idx < NPT_A) ? sb_q.rdy[q_idx] : 1'b0)
              | (set_en && set_idx == q_idx);
    end

endmodule

// File: rtl/regmap_sb.sv
module regmap_sb
    import regmap_pkg::*;
#(
    parameter int LOG_INT  = 8,
    parameter int PHYS_INT = 16,
    parameter int LOG_FP   = 8,
    parameter int PHYS_FP  = 16,
    parameter int NUM_MISC = 4,
    parameter int ZERO_INT = 0,
    parameter int ZERO_FP  = 8,
    localparam int NL  = LOG_INT + LOG_FP,
    localparam int NPF = PHYS_INT + PHYS_FP,
    localparam int NPT = NPF + NUM_MISC,
    localparam int AW  = $clog2(NL + NUM_MISC),
    localparam int PW  = $clog2(NPT),
    localparam int CW  = $clog2(((PHYS_INT > PHYS_FP) ? PHYS_INT : PHYS_FP) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_arch,
    output logic          ren_ready,
    output logic [PW-1:0] ren_new,
    output logic [PW-1:0] ren_prev,
    output logic          int_fl_pop,
    input  logic          int_fl_valid,
    input  logic [PW-1:0] int_fl_phys,
    input  logic [CW-1:0] int_fl_count,
    output logic          fp_fl_pop,
    input  logic          fp_fl_valid,
    input  logic [PW-1:0] fp_fl_phys,
    input  logic [CW-1:0] fp_fl_count,
    input  logic [AW-1:0] lk_arch,
    output logic [PW-1:0] lk_phys,
    input  logic          rdy_set,
    input  logic [PW-1:0] rdy_set_phys,
    input  logic [PW-1:0] rdy_query_phys,
    output logic          rdy_query_out,
    input  logic          ovr_valid,
    input  logic [AW-1:0] ovr_arch,
    input  logic [PW-1:0] ovr_phys,
    output logic [CW-1:0] avail_count
);
    localparam logic [AW-1:0] ZI_A = AW'(ZERO_INT);
    localparam logic [AW-1:0] ZF_A = AW'(ZERO_FP);
    localparam int NPORT = 2;   // port 0: rename, port 1: lookup

    logic [AW-1:0] cl_arch [NPORT];
    reg_class_e    cl_cls  [NPORT];
    logic [PW-1:0] cl_fix  [NPORT];

    assign cl_arch[0] = ren_arch;
    assign cl_arch[1] = lk_arch;

    for (genvar g = 0; g < NPORT; g++) begin : g_cls
        regmap_classify #(
            .LI (LOG_INT),
            .LF (LOG_FP),
            .NPF(NPF),
            .AW (AW),
            .PW (PW)
        ) cls_i (
            .arch      (cl_arch[g]),
            .cls       (cl_cls[g]),
            .fixed_phys(cl_fix[g])
        );
    end

    logic          rn_zero, need_int, need_fp, fire;
    logic          map_wr_en, ov_en, clr_en;
    logic [PW-1:0] map_a, map_b;

    always_comb begin
        rn_zero    = (ren_arch == ZI_A) || (ren_arch == ZF_A);
        need_int   = (cl_cls[0] == RC_INT) && !rn_zero;
        need_fp    = (cl_cls[0] == RC_FP) && !rn_zero;
        ren_ready  = !(need_int && !int_fl_valid) && !(need_fp && !fp_fl_valid);
        fire       = ren_valid && ren_ready;
        int_fl_pop = fire && need_int;
        fp_fl_pop  = fire && need_fp;

        if (cl_cls[0] == RC_MISC) begin
            ren_new  = cl_fix[0];
            ren_prev = cl_fix[0];
        end else begin
            ren_prev = map_a;
            if (rn_zero) begin
                ren_new = PW'(ren_arch);
            end else if (need_int) begin
                ren_new = int_fl_phys;
            end else begin
                ren_new = fp_fl_phys;
            end
        end

        map_wr_en = int_fl_pop || fp_fl_pop;
        ov_en     = ovr_valid;
        clr_en    = fire && !rn_zero;

        lk_phys     = (cl_cls[1] == RC_MISC) ? cl_fix[1] : map_b;
        avail_count = (int_fl_count < fp_fl_count) ? int_fl_count : fp_fl_count;
    end

    regmap_table #(
        .LI(LOG_INT),
        .LF(LOG_FP),
        .PI(PHYS_INT),
        .AW(AW),
        .PW(PW)
    ) map_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_wr_en),
        .wr_arch  (ren_arch),
        .wr_phys  (ren_new),
        .ov_en    (ov_en),
        .ov_arch  (ovr_arch),
        .ov_phys  (ovr_phys),
        .rd_a_arch(ren_arch),
        .rd_a_phys(map_a),
        .rd_b_arch(lk_arch),
        .rd_b_phys(map_b)
    );

    regmap_scoreboard #(
        .LI(LOG_INT),
        .PI(PHYS_INT),
        .LF(LOG_FP),
        .PF(PHYS_FP),
        .NM(NUM_MISC),
        .PW(PW)
    ) sb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (rdy_set),
        .set_idx(rdy_set_phys),
        .clr_en (clr_en),
        .clr_idx(ren_new),
        .q_idx  (rdy_query_phys),
        .q_rdy  (rdy_query_out)
    );

endmodule

// File: rtl/regmap_sb_chk.sv
module regmap_sb_chk #(
    parameter int LI  = 8,
    parameter int PI  = 16,
    parameter int LF  = 8,
    parameter int PF  = 16,
    parameter int NM  = 4,
    parameter int ZI  = 0,
    parameter int ZF  = 8,
    localparam int NL  = LI + LF,
    localparam int NPF = PI + PF,
    localparam int AW  = $clog2(NL + NM),
    localparam int PW  = $clog2(NPF + NM),
    localparam int CW  = $clog2(((PI > PF) ? PI : PF) + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid,
    input logic [AW-1:0] ren_arch,
    input logic          ren_ready,
    input logic [PW-1:0] ren_new,
    input logic [PW-1:0] ren_prev,
    input logic          int_fl_pop,
    input logic          int_fl_valid,
    input logic [PW-1:0] int_fl_phys,
    input logic [CW-1:0] int_fl_count,
    input logic          fp_fl_pop,
    input logic          fp_fl_valid,
    input logic [PW-1:0] fp_fl_phys,
    input logic [CW-1:0] fp_fl_count,
    input logic [AW-1:0] lk_arch,
    input logic [PW-1:0] lk_phys,
    input logic          rdy_set,
    input logic [PW-1:0] rdy_set_phys,
    input logic [PW-1:0] rdy_query_phys,
    input logic          rdy_query_out,
    input logic [CW-1:0] avail_count
);
    localparam logic [AW-1:0] LI_A = AW'(LI);
    localparam logic [AW-1:0] NL_A = AW'(NL);
    localparam logic [AW-1:0] NA_A = AW'(NL + NM);
    localparam logic [AW-1:0] ZI_A = AW'(ZI);
    localparam logic [AW-1:0] ZF_A = AW'(ZF);

    assert_int_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid && ren_ready && ren_arch < LI_A && ren_arch != ZI_A
        |-> int_fl_pop && !fp_fl_pop && ren_new == int_fl_phys);

    assert_fp_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid && ren_ready && ren_arch >= LI_A && ren_arch < NL_A && ren_arch != ZF_A
        |-> fp_fl_pop && !int_fl_pop && ren_new == fp_fl_phys);

    assert_zero_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid && (ren_arch == ZI_A || ren_arch == ZF_A)
        |-> ren_ready && !int_fl_pop && !fp_fl_pop && ren_new == PW'(ren_arch));

    assert_misc_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid && ren_arch >= NL_A && ren_arch < NA_A
        |-> ren_ready && ren_prev == ren_new && !int_fl_pop && !fp_fl_pop);

    assert_lookup_misc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_arch >= NL_A && lk_arch < NA_A
        |-> int'(lk_phys) == int'(lk_arch) - NL + NPF);

    assert_mark_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_set && rdy_set_phys == rdy_query_phys |-> rdy_query_out);

    assert_int_pop_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_fl_pop |-> int_fl_valid && ren_valid);

    assert_fp_pop_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fp_fl_pop |-> fp_fl_valid && ren_valid);

    assert_avail_min_R11: assert property (@(posedge clk) disable iff (!rst_n)
        avail_count <= int_fl_count && avail_count <= fp_fl_count
        && (avail_count == int_fl_count || avail_count == fp_fl_count));

endmodule

bind regmap_sb regmap_sb_chk #(
    .LI(LOG_INT),
    .PI(PHYS_INT),
    .LF(LOG_FP),
    .PF(PHYS_FP),
    .NM(NUM_MISC),
    .ZI(ZERO_INT),
    .ZF(ZERO_FP)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ren_valid     (ren_valid),
    .ren_arch      (ren_arch),
    .ren_ready     (ren_ready),
    .ren_new       (ren_new),
    .ren_prev      (ren_prev),
    .int_fl_pop    (int_fl_pop),
    .int_fl_valid  (int_fl_valid),
    .int_fl_phys   (int_fl_phys),
    .int_fl_count  (int_fl_count),
    .fp_fl_pop     (fp_fl_pop),
    .fp_fl_valid   (fp_fl_valid),
    .fp_fl_phys    (fp_fl_phys),
    .fp_fl_count   (fp_fl_count),
    .lk_arch       (lk_arch),
    .lk_phys       (lk_phys),
    .rdy_set       (rdy_set),
    .rdy_set_phys  (rdy_set_phys),
    .rdy_query_phys(rdy_query_phys),
    .rdy_query_out (rdy_query_out),
    .avail_count   (avail_count)
);

// File: tb/regmap_sb_tb_top.sv
`timescale 1ns/1ps
module regmap_sb_tb_top;
    localparam int LI  = 8;
    localparam int PI  = 16;
    localparam int LF  = 8;
    localparam int PF  = 16;
    localparam int NM  = 4;
    localparam int ZI  = 0;
    localparam int ZF  = 8;
    localparam int NL  = LI + LF;
    localparam int NPF = PI + PF;
    localparam int NPT = NPF + NM;
    localparam int NA  = NL + NM;
    localparam int AW  = $clog2(NA);
    localparam int PW  = $clog2(NPT);
    localparam int CW  = $clog2(((PI > PF) ? PI : PF) + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ren_valid;
    logic [AW-1:0] ren_arch;
    logic          ren_ready;
    logic [PW-1:0] ren_new, ren_prev;
    logic          int_fl_pop, int_fl_valid;
    logic [PW-1:0] int_fl_phys;
    logic [CW-1:0] int_fl_count;
    logic          fp_fl_pop, fp_fl_valid;
    logic [PW-1:0] fp_fl_phys;
    logic [CW-1:0] fp_fl_count;
    logic [AW-1:0] lk_arch;
    logic [PW-1:0] lk_phys;
    logic          rdy_set;
    logic [PW-1:0] rdy_set_phys, rdy_query_phys;
    logic          rdy_query_out;
    logic          ovr_valid;
    logic [AW-1:0] ovr_arch;
    logic [PW-1:0] ovr_phys;
    logic [CW-1:0] avail_count;

    regmap_sb #(
        .LOG_INT(LI), .PHYS_INT(PI), .LOG_FP(LF), .PHYS_FP(PF),
        .NUM_MISC(NM), .ZERO_INT(ZI), .ZERO_FP(ZF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_ready(ren_ready),
        .ren_new(ren_new), .ren_prev(ren_prev),
        .int_fl_pop(int_fl_pop), .int_fl_valid(int_fl_valid),
        .int_fl_phys(int_fl_phys), .int_fl_count(int_fl_count),
        .fp_fl_pop(fp_fl_pop), .fp_fl_valid(fp_fl_valid),
        .fp_fl_phys(fp_fl_phys), .fp_fl_count(fp_fl_count),
        .lk_arch(lk_arch), .lk_phys(lk_phys),
        .rdy_set(rdy_set), .rdy_set_phys(rdy_set_phys),
        .rdy_query_phys(rdy_query_phys), .rdy_query_out(rdy_query_out),
        .ovr_valid(ovr_valid), .ovr_arch(ovr_arch), .ovr_phys(ovr_phys),
        .avail_count(avail_count)
    );

    always #4 clk = ~clk;   // 125 MHz

    int map_m [NL];
    bit sb_m  [NPT];
    int qi [$];
    int qf [$];
    bit stall_i, stall_f;
    int cnt_i, cnt_f;
    int n_chk = 0;
    int n_err = 0;

    function automatic int cls_of(int a);
        if (a < LI) return 0;
        if (a < NL) return 1;
        return 2;
    endfunction

    task automatic chk(string r, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic step(bit rv, int ra, int la, bit ms, int mi, int qp,
                        bit ov, int oa, int op, string ltag, string qtag);
        int  c, enew, eprev, elk;
        bit  z, nint, nfp, erdy, efire, eq;
        string rtag;
        @(negedge clk);
        ren_valid      = rv;
        ren_arch       = AW'(ra);
        lk_arch        = AW'(la);
        rdy_set        = ms;
        rdy_set_phys   = PW'(mi);
        rdy_query_phys = PW'(qp);
        ovr_valid      = ov;
        ovr_arch       = AW'(oa);
        ovr_phys       = PW'(op);
        int_fl_valid   = !stall_i && qi.size() > 0;
        int_fl_phys    = (qi.size() > 0) ? PW'(qi[0]) : '0;
        fp_fl_valid    = !stall_f && qf.size() > 0;
        fp_fl_phys     = (qf.size() > 0) ? PW'(qf[0]) : '0;
        int_fl_count   = CW'(cnt_i);
        fp_fl_count    = CW'(cnt_f);
        #1;
        c     = cls_of(ra);
        z     = (c < 2) && (ra == ZI || ra == ZF);
        nint  = (c == 0) && !z;
        nfp   = (c == 1) && !z;
        erdy  = !(nint && !int_fl_valid) && !(nfp && !fp_fl_valid);
        efire = rv && erdy;
        rtag  = z ? "R5" : (c == 2) ? "R6" : "R3";
        if (c == 2) begin
            enew  = ra - NL + NPF;
            eprev = enew;
        end else begin
            eprev = map_m[ra];
            if (z) enew = ra;
            else if (nint) enew = int'(int_fl_phys);
            else enew = int'(fp_fl_phys);
        end
        if (rv) chk(erdy ? rtag : "R10 ready", int'(ren_ready), int'(erdy));
        chk(erdy ? rtag : "R10 int pop", int'(int_fl_pop), int'(efire && nint));
        chk(erdy ? rtag : "R10 fp pop", int'(fp_fl_pop), int'(efire && nfp));
        if (efire) begin
            chk({rtag, " new"}, int'(ren_new), enew);
            chk({rtag, " prev"}, int'(ren_prev), eprev);
        end
        elk = (cls_of(la) == 2) ? la - NL + NPF : map_m[la];
        chk({ltag, " lookup"}, int'(lk_phys), elk);
        eq = sb_m[qp] || (ms && mi == qp);
        chk({qtag, " query"}, int'(rdy_query_out), int'(eq));
        chk("R11 avail", int'(avail_count), (cnt_i < cnt_f) ? cnt_i : cnt_f);
        // model update for the coming edge
        if (ms) sb_m[mi] = 1'b1;
        if (efire && !z) sb_m[enew] = 1'b0;
        if (efire && nint) begin
            map_m[ra] = enew;
            void'(qi.pop_front());
            qi.push_back(eprev);
        end
        if (efire && nfp) begin
            map_m[ra] = enew;
            void'(qf.pop_front());
            qf.push_back(eprev);
        end
        if (ov && oa < NL) map_m[oa] = op;
    endtask

    task automatic idle(int la, int qp, string ltag, string qtag);
        step(1'b0, 0, la, 1'b0, 0, qp, 1'b0, 0, 0, ltag, qtag);
    endtask

    initial begin
        rst_n = 1'b0;
        ren_valid = 1'b0; ren_arch = '0; lk_arch = '0;
        rdy_set = 1'b0; rdy_set_phys = '0; rdy_query_phys = '0;
        ovr_valid = 1'b0; ovr_arch = '0; ovr_phys = '0;
        int_fl_valid = 1'b0; int_fl_phys = '0; int_fl_count = '0;
        fp_fl_valid = 1'b0; fp_fl_phys = '0; fp_fl_count = '0;
        stall_i = 1'b0; stall_f = 1'b0;
        cnt_i = PI - LI; cnt_f = PF - LF;
        for (int i = LI; i < PI; i++) qi.push_back(i);
        for (int i = PI + LF; i < NPF; i++) qf.push_back(i);
        for (int i = 0; i < NL; i++) map_m[i] = (i < LI) ? i : PI + i - LI;
        for (int i = 0; i < NPT; i++)
            sb_m[i] = (i < LI) || (i >= PI && i < PI + LF) || (i >= NPF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset mapping and ready bits
        for (int i = 0; i < NPT; i++) idle(i % NA, i, "R1", "R2");

        // R3 / R4 / R7: rename every non-zero int and fp register
        for (int a = 1; a < NL; a++) begin
            if (a == ZF) continue;
            step(1'b1, a, a, 1'b0, 0, 0, 1'b0, 0, 0, "R7", "R8");
            idle(a, map_m[a], "R3", "R4");
        end

        // R5: zero registers
        step(1'b1, ZI, ZI, 1'b0, 0, ZI, 1'b0, 0, 0, "R5", "R5");
        idle(ZI, ZI, "R5", "R5");
        step(1'b1, ZF, ZF, 1'b0, 0, ZF, 1'b0, 0, 0, "R5", "R5");
        idle(ZF, ZF, "R5", "R5");

        // R6 / R8: misc registers clear ready, mark bypass restores
        for (int a = NL; a < NA; a++) begin
            step(1'b1, a, a, 1'b0, 0, 0, 1'b0, 0, 0, "R6", "R8");
            idle(a, a - NL + NPF, "R6", "R6");
            step(1'b0, 0, 0, 1'b1, a - NL + NPF, a - NL + NPF, 1'b0, 0, 0, "R7", "R8");
        end

        // R8: mark every physical index, same-cycle and next-cycle query
        for (int p = 0; p < NPT; p++) begin
            step(1'b0, 0, 0, 1'b1, p, p, 1'b0, 0, 0, "R7", "R8");
            idle(0, p, "R7", "R8");
        end

        // R4: mark and rename clear of the same register in one cycle
        begin
            int h;
            h = qi[0];
            step(1'b1, 3, 3, 1'b1, h, h, 1'b0, 0, 0, "R7", "R8");
            idle(3, h, "R3", "R4");
        end

        // R10: stalled int rename, fp still flows; then the reverse
        stall_i = 1'b1;
        step(1'b1, 2, 2, 1'b0, 0, 0, 1'b0, 0, 0, "R7", "R8");
        idle(2, 0, "R10", "R2");
        step(1'b1, 10, 10, 1'b0, 0, 0, 1'b0, 0, 0, "R7", "R8");
        stall_i = 1'b0;
        stall_f = 1'b1;
        step(1'b1, 11, 11, 1'b0, 0, 0, 1'b0, 0, 0, "R7", "R8");
        idle(11, 0, "R10", "R2");
        step(1'b1, 4, 4, 1'b0, 0, 0, 1'b0, 0, 0, "R7", "R8");
        stall_f = 1'b0;

        // R9: override, override beating rename, misc override ignored
        step(1'b0, 0, 0, 1'b0, 0, 0, 1'b1, 5, 3, "R7", "R8");
        idle(5, 0, "R9", "R8");
        step(1'b1, 6, 6, 1'b0, 0, 0, 1'b1, 6, 7, "R7", "R8");
        idle(6, 0, "R9", "R8");
        step(1'b0, 0, 0, 1'b0, 0, 0, 1'b1, NL + 1, 1, "R7", "R8");
        idle(NL + 1, 0, "R9", "R8");
        idle(1, 0, "R9", "R8");

        // R11: sweep both free counts
        for (int i = 0; i <= PI; i++) begin
            for (int j = 0; j <= PF; j++) begin
                cnt_i = i;
                cnt_f = j;
                idle(0, 0, "R7", "R8");
            end
        end
        cnt_i = PI - LI;
        cnt_f = PF - LF;

        // mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            stall_i = ($urandom % 8) == 0;
            stall_f = ($urandom % 8) == 0;
            step(($urandom % 4) != 0, int'($urandom % NA), int'($urandom % NA),
                 ($urandom % 3) == 0, int'($urandom % NPT), int'($urandom % NPT),
                 ($urandom % 16) == 0, int'($urandom % NA), int'($urandom % NPT),
                 "R7", "R8");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule